// File: doc/BRIEF.md
# Memory-Mapped BCD Calendar Clock

This block is a calendar clock that lives in the top sixteen bytes of a byte-wide, SRAM-style address space. Below that window it behaves as ordinary byte storage. A host reads and writes it through a 15-bit address, an 8-bit data path and three active-low strobes for chip select, output enable and write. The asynchronous pins are sampled in a system clock domain. A write commits on the rising edge of the write strobe while chip select is low.

A one-cycle pulse from an external seconds prescaler advances a set of running counters. The counters hold time in packed BCD and use a 24-hour format. The host never reads those counters directly. It reads eight plain read/write cells that a refresh path overwrites with the new counter values on every seconds pulse. A control byte can stop that refresh. Software uses this to take a consistent snapshot, or to stage a new time that is copied into the counters when the staging bit is released. While the power-fail input is high, every write is discarded.

Top module: `calendar_rtc`

## Requirements
- R1: After reset the clock window reads as follows: seconds 00, minutes 00, hours 00, weekday 01, date 01, month 01, year 00, century 20 (hex), and control 00. The data output is not driven.
- R2: `dq_drive` is high only while `ce_n`=0, `oe_n`=0 and `we_n`=1. `dq_out` then carries the byte at `addr`.
- R3: A write stores `din` at `addr` in the cycle where `we_n` is seen rising while `ce_n` is low. With `ce_n` high, a write strobe changes nothing. Addresses outside the clock bytes act as plain storage.
- R4: While `pwr_fail` is 1, no write changes any byte, including the control byte and the clock bytes.
- R5: On each `tick_1hz` pulse the seconds advance in BCD. Seconds wrap 59 to 00 into minutes, minutes wrap 59 to 00 into hours, and hours wrap 23 to 00.
- R6: When the hour wraps, the weekday advances and goes from 07 back to 01.
- R7: The date wraps to 01 after 30 in months 04, 06, 09 and 11, and after 31 in all other months except February. The month then advances.
- R8: February ends on 29 when the BCD year is divisible by 4, and on 28 otherwise.
- R9: Month 12 wraps to 01 and advances the year. Year 99 wraps to 00 and advances the century.
- R10: With control bits 7 and 6 both clear, each pulse copies the advanced counters into the visible bytes. With bit 6 set, the visible bytes hold their value while the counters keep running. After bit 6 clears, the next pulse shows the running time.
- R11: With control bit 7 set, host writes to the clock bytes persist across pulses. A control write that changes bit 7 from 1 to 0 loads all eight visible bytes into the counters. This load takes priority over a pulse in the same cycle.
- R12: The address map, in hex, is: century 7FF1, control 7FF8, seconds 7FF9, minutes 7FFA, hours 7FFB, weekday 7FFC, date 7FFD, month 7FFE, year 7FFF. Control bits 5:0 are kept as written and read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1hz | input | 1 | One-cycle seconds pulse |
| pwr_fail | input | 1 | High blocks all writes |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low, commits on rise |
| addr | input | 15 | Byte address |
| din | input | 8 | Write data |
| dq_out | output | 8 | Read data |
| dq_drive | output | 1 | High when `dq_out` is driven, low means high impedance |

## Verification
On every cycle the assertions check four things. The running seconds, hours and weekday always hold legal BCD values. Each pulse changes the seconds unless a load wins that cycle. The control byte stays frozen under power fail. With either control bit set, the visible seconds byte changes only through a host write. Only the bench scenarios can show the calendar arithmetic: month lengths, leap Februaries, and the year and century carries. Those scenarios also cover staging through bit 7, the snapshot behaviour of bit 6 and the storage aliasing, all observed at the read port.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

   typedef struct packed {
      logic [7:0] cent;
      logic [7:0] yr;
      logic [7:0] mon;
      logic [7:0] date;
      logic [7:0] day;
      logic [7:0] hr;
      logic [7:0] min;
      logic [7:0] sec;
   } rtc_time_t;

   localparam int NUM_TBYTES = 8;

   function automatic logic [7:0] bcd_inc(input logic [7:0] v);
      if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
      else                return {v[7:4], v[3:0] + 4'd1};
   endfunction

   // (10*tens + ones) mod 4 == (2*tens[0] + ones) mod 4
   function automatic logic leap_year(input logic [7:0] yr);
      logic [1:0] s;
      s = {yr[4], 1'b0} + yr[1:0];
      return (s == 2'd0);
   endfunction

   function automatic logic [7:0] month_last(input logic [7:0] mon, input logic [7:0] yr);
      case (mon)
         8'h02:                      return leap_year(yr) ? 8'h29 : 8'h28;
         8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
         default:                    return 8'h31;
      endcase
   endfunction

   function automatic rtc_time_t next_time(input rtc_time_t t);
      rtc_time_t n;
      n = t;
      if (t.sec != 8'h59) n.sec = bcd_inc(t.sec);
      else begin
         n.sec = 8'h00;
         if (t.min != 8'h59) n.min = bcd_inc(t.min);
         else begin
            n.min = 8'h00;
            if (t.hr != 8'h23) n.hr = bcd_inc(t.hr);
            else begin
               n.hr  = 8'h00;
               n.day = (t.day == 8'h07) ? 8'h01 : bcd_inc(t.day);
               if (t.date != month_last(t.mon, t.yr)) n.date = bcd_inc(t.date);
               else begin
                  n.date = 8'h01;
                  if (t.mon != 8'h12) n.mon = bcd_inc(t.mon);
                  else begin
                     n.mon = 8'h01;
                     if (t.yr != 8'h99) n.yr = bcd_inc(t.yr);
                     else begin
                        n.yr   = 8'h00;
                        n.cent = (t.cent == 8'h99) ? 8'h00 : bcd_inc(t.cent);
                     end
                  end
               end
            end
         end
      end
      return n;
   endfunction

endpackage

// File: rtl/rtc_time_core.sv
module rtc_time_core
   import rtc_pkg::*;
#(
   parameter logic [7:0] RESET_CENTURY = 8'h20
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      tick,
   input  logic      load,
   input  rtc_time_t load_val,
   output rtc_time_t cnt,
   output rtc_time_t cnt_next
);

   localparam rtc_time_t RESET_TIME = '{cent: RESET_CENTURY, yr: 8'h00, mon: 8'h01,
                                        date: 8'h01, day: 8'h01, hr: 8'h00,
                                        min: 8'h00, sec: 8'h00};

   assign cnt_next = next_time(cnt);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= RESET_TIME;
      else if (load) cnt <= load_val;
      else if (tick) cnt <= cnt_next;
   end

endmodule

// File: rtl/rtc_store.sv
module rtc_store #(
   parameter int AW             = 6,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [7:0]    wdata,
   input  logic [AW-1:0] raddr,
   output logic [7:0]    rdata
);

   localparam int DEPTH = 1 << AW;

   logic [7:0] mem [DEPTH];

   generate
      if (CLEAR_ON_RESET) begin : g_clr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
            end else if (we) begin
               mem[waddr] <= wdata;
            end
         end
      end else begin : g_noclr
         always_ff @(posedge clk) begin
            if (we) mem[waddr] <= wdata;
         end
      end
   endgenerate

   assign rdata = mem[raddr];

endmodule

// File: rtl/calendar_rtc.sv
module calendar_rtc
   import rtc_pkg::*;
#(
   parameter int         ADDR_W         = 15,
   parameter int         RAM_AW         = 6,
   parameter bit         RAM_CLEAR      = 1'b1,
   parameter logic [7:0] RESET_CENTURY  = 8'h20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_1hz,
   input  logic              pwr_fail,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        din,
   output logic [7:0]        dq_out,
   output logic              dq_drive
);

   localparam int          HI_W     = ADDR_W - 4;
   localparam logic [3:0]  OFF_CENT = 4'h1;
   localparam logic [3:0]  OFF_CTRL = 4'h8;
   localparam logic [3:0]  OFF_SEC  = 4'h9;
   localparam int          BIT_STAGE  = 7;
   localparam int          BIT_FREEZE = 6;

   generate
      if (ADDR_W < 5) begin : g_bad_aw
         $error("calendar_rtc: ADDR_W must be at least 5");
      end
      if (RAM_AW < 1 || RAM_AW >= ADDR_W || RAM_AW > 12) begin : g_bad_ram
         $error("calendar_rtc: RAM_AW out of range");
      end
   endgenerate

   // write strobe on sampled rising edge of we_n
   logic we_q;
   logic wr_stb;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) we_q <= 1'b1;
      else        we_q <= we_n;
   end
   assign wr_stb = we_n && !we_q && !ce_n && !pwr_fail;

   // address decode
   logic       in_win;
   logic [3:0] off;
   logic       hit_ctrl;
   logic       hit_clk;
   logic [2:0] vidx;
   assign in_win   = &addr[ADDR_W-1:4];
   assign off      = addr[3:0];
   assign hit_ctrl = in_win && (off == OFF_CTRL);
   assign hit_clk  = in_win && ((off == OFF_CENT) || (off >= OFF_SEC));
   assign vidx     = (off == OFF_CENT) ? 3'd7 : 3'(off - OFF_SEC);

   // control byte
   logic [7:0] ctrl_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    ctrl_q <= 8'h00;
      else if (wr_stb && hit_ctrl)   ctrl_q <= din;
   end

   logic copy_en;
   logic load_cnt;
   assign copy_en  = !ctrl_q[BIT_STAGE] && !ctrl_q[BIT_FREEZE];
   assign load_cnt = wr_stb && hit_ctrl && ctrl_q[BIT_STAGE] && !din[BIT_STAGE];

   // running counters
   rtc_time_t cnt;
   rtc_time_t cnt_next;
   rtc_time_t vis_t;
   logic [7:0] vis [NUM_TBYTES];

   assign vis_t = {vis[7], vis[6], vis[5], vis[4], vis[3], vis[2], vis[1], vis[0]};

   rtc_time_core #(.RESET_CENTURY(RESET_CENTURY)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick_1hz),
      .load     (load_cnt),
      .load_val (vis_t),
      .cnt      (cnt),
      .cnt_next (cnt_next)
   );

   // visible clock bytes: index 0 = seconds ... 6 = year, 7 = century
   logic [8*NUM_TBYTES-1:0] next_flat;
   logic [8*NUM_TBYTES-1:0] rst_flat;
   assign next_flat = cnt_next;
   assign rst_flat  = {RESET_CENTURY, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

   generate
      for (genvar i = 0; i < NUM_TBYTES; i++) begin : g_vis
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                    vis[i] <= rst_flat[8*i +: 8];
            else if (wr_stb && hit_clk && vidx == 3'(i))   vis[i] <= din;
            else if (tick_1hz && copy_en)                  vis[i] <= next_flat[8*i +: 8];
         end
      end
   endgenerate

   logic [7:0] vis_sec;
   assign vis_sec = vis[0];

   // general storage
   logic [7:0] ram_rd;
   rtc_store #(.AW(RAM_AW), .CLEAR_ON_RESET(RAM_CLEAR)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_stb && !hit_ctrl && !hit_clk),
      .waddr (addr[RAM_AW-1:0]),
      .wdata (din),
      .raddr (addr[RAM_AW-1:0]),
      .rdata (ram_rd)
   );

   // read path
   always_comb begin
      if (hit_ctrl)     dq_out = ctrl_q;
      else if (hit_clk) dq_out = vis[vidx];
      else              dq_out = ram_rd;
   end
   assign dq_drive = !ce_n && !oe_n && we_n;

endmodule

// File: rtl/calendar_rtc_chk.sv
module calendar_rtc_chk
   import rtc_pkg::*;
(
   input logic      clk,
   input logic      rst_n,
   input logic      tick_1hz,
   input logic      pwr_fail,
   input logic      load_cnt,
   input logic      wr_stb,
   input logic [7:0] ctrl_q,
   input logic [7:0] vis_sec,
   input rtc_time_t cnt
);

   // R5
   sec_bcd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt.sec[3:0] <= 4'd9) && (cnt.sec <= 8'h59) && (cnt.hr <= 8'h23));

   // R6
   day_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt.day >= 8'h01) && (cnt.day <= 8'h07));

   // R5
   tick_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_1hz && !load_cnt) |=> (cnt.sec != $past(cnt.sec)));

   // R4
   pf_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_fail |=> $stable(ctrl_q));

   // R10
   freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[6] && !wr_stb) |=> $stable(vis_sec));

   // R11
   stage_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[7] && !wr_stb) |=> $stable(vis_sec));

endmodule

bind calendar_rtc calendar_rtc_chk u_chk (.*);

// File: tb/calendar_rtc_tb.sv
module calendar_rtc_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_1hz = 1'b0;
   logic        pwr_fail = 1'b0;
   logic        ce_n = 1'b1;
   logic        oe_n = 1'b1;
   logic        we_n = 1'b1;
   logic [14:0] addr = '0;
   logic [7:0]  din = '0;
   logic [7:0]  dq_out;
   logic        dq_drive;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct { logic [7:0] exp; string tag; } exp_t;
   exp_t sb_q [$];
   event mon_ev;

   always #5 clk = ~clk;

   calendar_rtc u_dut (
      .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .pwr_fail(pwr_fail),
      .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .addr(addr), .din(din),
      .dq_out(dq_out), .dq_drive(dq_drive)
   );

   localparam logic [14:0] A_CENT = 15'h7FF1, A_CTRL = 15'h7FF8, A_SEC = 15'h7FF9,
                           A_MIN = 15'h7FFA, A_HR = 15'h7FFB, A_DAY = 15'h7FFC,
                           A_DATE = 15'h7FFD, A_MON = 15'h7FFE, A_YR = 15'h7FFF;

   // monitor: pops the scoreboard when a read is presented
   always begin
      @(mon_ev);
      begin
         exp_t e;
         e = sb_q.pop_front();
         checks++;
         if (!dq_drive || dq_out !== e.exp) begin
            errors++;
            $display("FAIL %s: got %h drive %b, expected %h drive 1", e.tag, dq_out, dq_drive, e.exp);
         end
      end
   end

   task automatic rd(input logic [14:0] a, input logic [7:0] exp, input string tag);
      @(negedge clk);
      addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
      sb_q.push_back('{exp: exp, tag: tag});
      #2 -> mon_ev;
      @(negedge clk);
      ce_n = 1'b1; oe_n = 1'b1;
   endtask

   task automatic wr(input logic [14:0] a, input logic [7:0] d, input logic cen);
      @(negedge clk);
      addr = a; din = d; ce_n = cen; oe_n = 1'b1; we_n = 1'b0;
      @(negedge clk);
      we_n = 1'b1;
      @(negedge clk);
      ce_n = 1'b1;
   endtask

   task automatic tick();
      @(negedge clk); tick_1hz = 1'b1;
      @(negedge clk); tick_1hz = 1'b0;
   endtask

   task automatic chk_drive(input logic c, input logic o, input logic w, input string tag);
      @(negedge clk);
      ce_n = c; oe_n = o; we_n = w;
      #2;
      checks++;
      if (dq_drive !== 1'b0) begin
         errors++;
         $display("FAIL %s: drive %b, expected 0", tag, dq_drive);
      end
      ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
   endtask

   task automatic set_time(input logic [7:0] c, y, mo, dt, dy, h, mi, s);
      wr(A_CTRL, 8'h80, 1'b0);
      wr(A_CENT, c, 1'b0); wr(A_YR, y, 1'b0); wr(A_MON, mo, 1'b0);
      wr(A_DATE, dt, 1'b0); wr(A_DAY, dy, 1'b0); wr(A_HR, h, 1'b0);
      wr(A_MIN, mi, 1'b0); wr(A_SEC, s, 1'b0);
      wr(A_CTRL, 8'h00, 1'b0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset contents
      rd(A_SEC, 8'h00, "R1 sec"); rd(A_MIN, 8'h00, "R1 min"); rd(A_HR, 8'h00, "R1 hr");
      rd(A_DAY, 8'h01, "R1 day"); rd(A_DATE, 8'h01, "R1 date"); rd(A_MON, 8'h01, "R1 mon");
      rd(A_YR, 8'h00, "R1 yr"); rd(A_CENT, 8'h20, "R1 cent"); rd(A_CTRL, 8'h00, "R1 ctrl");
      chk_drive(1'b1, 1'b1, 1'b1, "R1 idle");

      // R2 output gating
      chk_drive(1'b0, 1'b1, 1'b1, "R2 oe high");
      chk_drive(1'b1, 1'b0, 1'b1, "R2 ce high");
      chk_drive(1'b0, 1'b0, 1'b0, "R2 we low");

      // R5 basic tick
      tick();
      rd(A_SEC, 8'h01, "R5 first tick");

      // R3 plain storage and ce gating
      wr(15'h0010, 8'hA5, 1'b0);
      wr(15'h0021, 8'h3C, 1'b0);
      rd(15'h0010, 8'hA5, "R3 store a");
      rd(15'h0021, 8'h3C, "R3 store b");
      wr(15'h0010, 8'h77, 1'b1);
      rd(15'h0010, 8'hA5, "R3 ce high ignored");

      // R4 power fail
      pwr_fail = 1'b1;
      wr(15'h0010, 8'h5A, 1'b0);
      wr(A_CTRL, 8'h40, 1'b0);
      wr(A_MIN, 8'h33, 1'b0);
      pwr_fail = 1'b0;
      rd(15'h0010, 8'hA5, "R4 ram blocked");
      rd(A_CTRL, 8'h00, "R4 ctrl blocked");
      rd(A_MIN, 8'h00, "R4 clock byte blocked");

      // R12 calibration bits read back
      wr(A_CTRL, 8'h15, 1'b0);
      rd(A_CTRL, 8'h15, "R12 ctrl low bits");
      wr(A_CTRL, 8'h00, 1'b0);

      // R5 R6 R7 R9: Dec 31 23:59:59, year 99, weekday 7
      set_time(8'h20, 8'h99, 8'h12, 8'h31, 8'h07, 8'h23, 8'h59, 8'h59);
      tick();
      rd(A_SEC, 8'h00, "R5 sec wrap"); rd(A_MIN, 8'h00, "R5 min wrap"); rd(A_HR, 8'h00, "R5 hr wrap");
      rd(A_DAY, 8'h01, "R6 weekday 7 to 1"); rd(A_DATE, 8'h01, "R7 date wrap 31");
      rd(A_MON, 8'h01, "R9 month wrap"); rd(A_YR, 8'h00, "R9 year wrap"); rd(A_CENT, 8'h21, "R9 century carry");

      // R7 thirty-day month
      set_time(8'h20, 8'h25, 8'h04, 8'h30, 8'h02, 8'h23, 8'h59, 8'h59);
      tick();
      rd(A_DATE, 8'h01, "R7 April 30 wrap"); rd(A_MON, 8'h05, "R7 month advance");
      rd(A_DAY, 8'h03, "R6 weekday advance");

      // R8 non-leap Feb
      set_time(8'h20, 8'h23, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
      tick();
      rd(A_DATE, 8'h01, "R8 Feb 28 non-leap"); rd(A_MON, 8'h03, "R8 to March");
      // R8 leap Feb
      set_time(8'h20, 8'h24, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
      tick();
      rd(A_DATE, 8'h29, "R8 Feb 29 leap"); rd(A_MON, 8'h02, "R8 stays Feb");
      tick();
      rd(A_SEC, 8'h01, "R5 sec after midnight");
      set_time(8'h20, 8'h12, 8'h02, 8'h29, 8'h01, 8'h23, 8'h59, 8'h59);
      tick();
      rd(A_DATE, 8'h01, "R8 Feb 29 wrap"); rd(A_MON, 8'h03, "R8 leap to March");

      // R10 freeze snapshot while counters run
      set_time(8'h20, 8'h30, 8'h06, 8'h15, 8'h04, 8'h10, 8'h00, 8'h00);
      wr(A_CTRL, 8'h40, 1'b0);
      tick(); tick(); tick();
      rd(A_SEC, 8'h00, "R10 frozen");
      wr(A_CTRL, 8'h00, 1'b0);
      rd(A_SEC, 8'h00, "R10 held until pulse");
      tick();
      rd(A_SEC, 8'h04, "R10 running time shown");

      // R10 unfrozen writes are overwritten by next pulse
      wr(A_SEC, 8'h30, 1'b0);
      rd(A_SEC, 8'h30, "R10 cell written");
      tick();
      rd(A_SEC, 8'h05, "R10 refresh overwrites");

      // R11 staging persists, load on release
      wr(A_CTRL, 8'h80, 1'b0);
      wr(A_SEC, 8'h45, 1'b0);
      tick(); tick();
      rd(A_SEC, 8'h45, "R11 staged value kept");
      wr(A_CTRL, 8'h00, 1'b0);
      tick();
      rd(A_SEC, 8'h46, "R11 loaded then advanced");
      rd(A_MIN, 8'h00, "R11 minutes loaded");

      // R11 load beats simultaneous pulse
      wr(A_CTRL, 8'h80, 1'b0);
      wr(A_SEC, 8'h20, 1'b0);
      @(negedge clk);
      addr = A_CTRL; din = 8'h00; ce_n = 1'b0; we_n = 1'b0;
      @(negedge clk);
      we_n = 1'b1; tick_1hz = 1'b1;
      @(negedge clk);
      ce_n = 1'b1; tick_1hz = 1'b0;
      tick();
      rd(A_SEC, 8'h21, "R11 load wins over pulse");

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule